// File: doc/BRIEF.md
# Dual-Target I2C Slave Front End

This block is a single I2C slave that answers on the bus as two logical targets. The first is a small register file for an I/O expander. The second is a byte-wide nonvolatile store, modelled here as on-chip RAM. The upper four bits of the received 7-bit address pick the target. The lower three bits must equal a strap parameter. After the address, the expander takes one pointer byte. The store takes a two-byte word address, high byte first. Data bytes then follow. Both pointers advance by one after every data byte, whether written or read. A repeated START followed by a read address returns data from wherever the pointer stands.

Writes to the store are gated in two ways. While the write-block input is high, store data bytes are still acknowledged but nothing is written. Bit 0 of expander register 0 enables the store. When that bit is cleared, the store's address is not acknowledged at all. SCL and SDA pass through a two-flop synchronizer. SDA is only ever pulled low and is released at all other times.

The control is a byte-level state machine with six states:
- `ST_IDLE`: waiting for a START.
- `ST_ADDR`: shifting in the address byte.
- `ST_ACK`: the slave drives the acknowledge bit.
- `ST_RX`: shifting in a data byte.
- `ST_TX`: shifting out a data byte.
- `ST_MACK`: sampling the master's acknowledge.

The transitions are:
- A START from any state goes to `ST_ADDR`, and a STOP from any state goes to `ST_IDLE`.
- `ST_ADDR` goes to `ST_ACK` on an address match and to `ST_IDLE` on a mismatch.
- `ST_ACK` goes to `ST_TX` for a read and to `ST_RX` for a write.
- `ST_RX` goes to `ST_ACK` after eight bits.
- `ST_TX` goes to `ST_MACK` after eight bits.
- `ST_MACK` goes to `ST_TX` on an ACK and to `ST_IDLE` on a NACK.

Top module: `dual_i2c_target`

## Requirements
- R1: The expander is addressed by address bits [6:3] = 4'b0100 and the store by bits [6:3] = 4'b1010. Bits [2:0] must equal `DEV_SEL` (default 0), giving addresses 0x20 and 0x50. Any other address is NACKed, and the slave stays silent until the next START.
- R2: In an expander write, the first data byte sets the register pointer (its low 3 bits select one of 8 registers). Each later byte writes the selected register. Every byte is ACKed. Register 1 drives `exp_out`.
- R3: The register pointer increments after each data byte written or read, and wraps from 7 to 0.
- R4: In a store write, the two bytes after the address form the word address, high byte first. Only the low `MEM_AW` bits are kept (default 9). The bytes that follow are stored starting at that address.
- R5: The store pointer increments after each data byte written or read, and wraps from 511 to 0.
- R6: A repeated START followed by a read address returns data starting at the current pointer of the selected target.
- R7: While `wr_block` is high, store data bytes are ACKed but the stored bytes stay unchanged. The pointer still advances.
- R8: Bit 0 of register 0 is the store enable. While it is 0, the store address is NACKed. Setting it to 1 makes the store answer again.
- R9: A master NACK ends a read. The slave then releases SDA and does not drive it again, even if clocking continues, until the next START.
- R10: After reset, SDA is released, register 0 holds 0x01 and registers 1 to 7 hold 0x00.
- R11: A STOP at any point abandons the transfer in progress, and the next START begins a fresh address phase.
- R12: The slave never changes its SDA drive while synchronized SCL stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| wr_block | input | 1 | High blocks writes into the store |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| exp_out | output | 8 | Contents of expander register 1 |

## Verification
The hardest case to reach is a write that the write-block input suppresses. The bus shows nothing different: the byte is still acknowledged, and only a later read-back can show that the stored byte is unchanged. The stimulus first stores known bytes, then raises the block input and overwrites those same locations with different values. It then lowers the block input, sets the pointer again with a write followed by a repeated START, and reads the original bytes back. Pointer wrap is reached in the same way, by loading the pointer with its last location (with out-of-range high bits set) and running two bytes across the boundary in both directions.

// File: rtl/dti_pkg.sv
package dti_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_RX,
        ST_TX,
        ST_MACK
    } dti_state_e;

    typedef enum logic {
        TGT_EXP,
        TGT_MEM
    } dti_tgt_e;
endpackage

// File: rtl/dti_bus_sync.sv
module dti_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_hold_hi,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES-1:0] scl_ff, sda_ff;
    logic scl_q, sda_q, scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_q  <= scl_ff[STAGES-1];
            sda_q  <= sda_ff[STAGES-1];
        end
    end

    assign scl_s       = scl_ff[STAGES-1];
    assign sda_s       = sda_ff[STAGES-1];
    assign scl_hold_hi = scl_s & scl_q;
    assign scl_rise    = scl_s & ~scl_q;
    assign scl_fall    = ~scl_s & scl_q;
    assign start_ev    = scl_hold_hi & sda_q & ~sda_s;
    assign stop_ev     = scl_hold_hi & ~sda_q & sda_s;
endmodule

// File: rtl/dti_regfile.sv
module dti_regfile #(
    parameter int          NREG     = 8,
    parameter logic [7:0]  CTRL_RST = 8'h01
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ptr_load,
    input  logic [7:0] ptr_din,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       rd_inc,
    output logic [7:0] rd_data,
    output logic       mem_en,
    output logic [7:0] out_q
);
    localparam int PW = $clog2(NREG);
    localparam logic [PW-1:0] LAST = PW'(NREG - 1);

    logic [7:0]    regs [NREG];
    logic [PW-1:0] ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (ptr_load) begin
            ptr <= PW'(ptr_din);
        end else if (wr_en || rd_inc) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= (i == 0) ? CTRL_RST : 8'h00;
            end
        end else if (wr_en) begin
            regs[ptr] <= wr_data;
        end
    end

    assign rd_data = regs[ptr];
    assign mem_en  = regs[0][0];
    assign out_q   = regs[1];

    assert_reg_ptr_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en || rd_inc) && !ptr_load && ptr == LAST) |=> (ptr == '0));
endmodule

// File: rtl/dti_mem.sv
module dti_mem #(
    parameter int AW = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hi_load,
    input  logic       lo_load,
    input  logic [7:0] addr_byte,
    input  logic       wr_req,
    input  logic [7:0] wr_data,
    input  logic       wr_block,
    input  logic       rd_inc,
    output logic [7:0] rd_data
);
    localparam int DEPTH = 1 << AW;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [7:0]    store [DEPTH];
    logic [7:0]    hi_q;
    logic [AW-1:0] ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            ptr  <= '0;
        end else begin
            if (hi_load) hi_q <= addr_byte;
            if (lo_load) begin
                ptr <= AW'({hi_q, addr_byte});
            end else if (wr_req || rd_inc) begin
                ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_req && !wr_block) store[ptr] <= wr_data;
    end

    assign rd_data = store[ptr];

    assert_mem_ptr_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_req || rd_inc) && !lo_load && ptr == LAST) |=> (ptr == '0));

    assert_blocked_keeps_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_block) |=> (store[$past(ptr)] == $past(store[ptr])));
endmodule

// File: rtl/dual_i2c_target.sv
module dual_i2c_target
    import dti_pkg::*;
#(
    parameter logic [2:0] DEV_SEL     = 3'b000,
    parameter logic [3:0] EXP_HI      = 4'b0100,
    parameter logic [3:0] MEM_HI      = 4'b1010,
    parameter int         NREG        = 8,
    parameter int         MEM_AW      = 9,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       wr_block,
    output logic       sda_oe,
    output logic [7:0] exp_out
);
    logic sda_s, scl_hold_hi, scl_rise, scl_fall, start_ev, stop_ev;

    dti_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_s      (sda_s),
        .scl_hold_hi(scl_hold_hi),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_ev   (start_ev),
        .stop_ev    (stop_ev)
    );

    dti_state_e state_q, state_d;
    dti_tgt_e   tgt_q;
    logic [3:0] bit_cnt;
    logic [7:0] shreg, txreg;
    logic [1:0] byte_idx;
    logic       ack_to_tx, nack_q;
    logic       mem_en;
    logic [7:0] reg_rd, mem_rd, rd_byte;
    logic       rx_done, hit_exp, hit_mem, byte_done, load_rd;

    assign rx_done   = (bit_cnt == 4'd8) && scl_fall;
    assign hit_exp   = (shreg[7:4] == EXP_HI) && (shreg[3:1] == DEV_SEL);
    assign hit_mem   = (shreg[7:4] == MEM_HI) && (shreg[3:1] == DEV_SEL) && mem_en;
    assign byte_done = (state_q == ST_RX) && rx_done;
    assign load_rd   = ((state_q == ST_ACK) && scl_fall && ack_to_tx) ||
                       ((state_q == ST_MACK) && scl_fall && !nack_q);
    assign rd_byte   = (tgt_q == TGT_MEM) ? mem_rd : reg_rd;

    dti_regfile #(.NREG(NREG), .CTRL_RST(8'h01)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .ptr_load(byte_done && tgt_q == TGT_EXP && byte_idx == 2'd0),
        .ptr_din (shreg),
        .wr_en   (byte_done && tgt_q == TGT_EXP && byte_idx != 2'd0),
        .wr_data (shreg),
        .rd_inc  (load_rd && tgt_q == TGT_EXP),
        .rd_data (reg_rd),
        .mem_en  (mem_en),
        .out_q   (exp_out)
    );

    dti_mem #(.AW(MEM_AW)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .hi_load  (byte_done && tgt_q == TGT_MEM && byte_idx == 2'd0),
        .lo_load  (byte_done && tgt_q == TGT_MEM && byte_idx == 2'd1),
        .addr_byte(shreg),
        .wr_req   (byte_done && tgt_q == TGT_MEM && byte_idx == 2'd2),
        .wr_data  (shreg),
        .wr_block (wr_block),
        .rd_inc   (load_rd && tgt_q == TGT_MEM),
        .rd_data  (mem_rd)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (start_ev) begin
            state_d = ST_ADDR;
        end else if (stop_ev) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_ADDR: if (rx_done) state_d = (hit_exp || hit_mem) ? ST_ACK : ST_IDLE;
                ST_ACK:  if (scl_fall) state_d = ack_to_tx ? ST_TX : ST_RX;
                ST_RX:   if (rx_done) state_d = ST_ACK;
                ST_TX:   if (scl_fall && bit_cnt == 4'd7) state_d = ST_MACK;
                ST_MACK: if (scl_fall) state_d = nack_q ? ST_IDLE : ST_TX;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Datapath and bus outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            shreg     <= '0;
            txreg     <= '0;
            byte_idx  <= '0;
            ack_to_tx <= 1'b0;
            nack_q    <= 1'b0;
            tgt_q     <= TGT_EXP;
            sda_oe    <= 1'b0;
        end else if (start_ev) begin
            bit_cnt  <= '0;
            byte_idx <= '0;
            sda_oe   <= 1'b0;
        end else if (stop_ev) begin
            sda_oe <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: sda_oe <= 1'b0;
                ST_ADDR, ST_RX: begin
                    if (scl_rise && bit_cnt != 4'd8) begin
                        shreg   <= {shreg[6:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    if (rx_done) begin
                        if (state_q == ST_ADDR) begin
                            tgt_q     <= hit_mem ? TGT_MEM : TGT_EXP;
                            ack_to_tx <= shreg[0];
                            sda_oe    <= hit_exp || hit_mem;
                        end else begin
                            ack_to_tx <= 1'b0;
                            sda_oe    <= 1'b1;
                            if (byte_idx != 2'd2) byte_idx <= byte_idx + 1'b1;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (ack_to_tx) begin
                            txreg  <= rd_byte;
                            sda_oe <= ~rd_byte[7];
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (bit_cnt == 4'd7) begin
                            sda_oe <= 1'b0;
                        end else begin
                            txreg   <= {txreg[6:0], 1'b0};
                            sda_oe  <= ~txreg[6];
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) nack_q <= sda_s;
                    if (scl_fall && !nack_q) begin
                        txreg   <= rd_byte;
                        sda_oe  <= ~rd_byte[7];
                        bit_cnt <= '0;
                    end
                end
                default: sda_oe <= 1'b0;
            endcase
        end
    end

    assert_sda_still_scl_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_hold_hi && !start_ev && !stop_ev) |-> $stable(sda_oe));

    assert_mem_off_nack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR && rx_done && shreg[7:4] == MEM_HI && !mem_en) |=> !sda_oe);

    assert_nack_ends_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MACK && scl_fall && nack_q) |=> (state_q == ST_IDLE && !sda_oe));

    assert_addr_miss_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR && rx_done && !hit_exp && !hit_mem) |=> !sda_oe);
endmodule

// File: tb/dual_i2c_target_tb.sv
module dual_i2c_target_tb;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic wr_block = 1'b0;
    logic sda_oe;
    logic [7:0] exp_out;
    logic sda_line;

    int n_chk = 0;
    int n_err = 0;
    int    exp_q[$];
    int    act_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_line = m_sda & ~sda_oe;

    dual_i2c_target u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (m_scl),
        .sda_i   (sda_line),
        .wr_block(wr_block),
        .sda_oe  (sda_oe),
        .exp_out (exp_out)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: got %0h expected %0h", tag, act, expv);
        end
    endtask

    // Monitor: pops expected items as observed results arrive
    initial begin
        forever begin
            @(negedge clk);
            while (act_q.size() > 0) begin
                int a;
                a = act_q.pop_front();
                if (exp_q.size() == 0) begin
                    check(1'b0, "scoreboard underflow", a, -1);
                end else begin
                    int e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(a == e, t, a, e);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic put_bit(input logic b);
        m_sda = b; tick(Q); m_scl = 1'b1; tick(Q); m_scl = 1'b0; tick(2);
    endtask

    task automatic i2c_start();
        m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(2);
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
    endtask

    task automatic wr(input string tag, input logic [7:0] b, input int exp_ack);
        logic a;
        exp_q.push_back(exp_ack); tag_q.push_back(tag);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q/2);
        @(negedge clk); a = ~sda_line;
        tick(Q/2); m_scl = 1'b0; tick(2);
        act_q.push_back(int'(a));
    endtask

    task automatic rd(input string tag, input logic [7:0] expv, input bit last);
        logic [7:0] v;
        logic s0, s1;
        v = '0;
        exp_q.push_back(int'(expv)); tag_q.push_back(tag);
        m_sda = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(Q); m_scl = 1'b1; tick(2);
            @(negedge clk); s0 = sda_line;
            tick(Q-4);
            @(negedge clk); s1 = sda_line;
            check(s0 == s1, "R12 SDA moved while SCL high", int'(s1), int'(s0));
            v = {v[6:0], s1};
            tick(1); m_scl = 1'b0; tick(2);
        end
        put_bit(last);
        m_sda = 1'b1;
        act_q.push_back(int'(v));
    endtask

    task automatic set_mem_ptr(input logic [7:0] hi, input logic [7:0] lo);
        wr("R1 store addr ack", 8'hA0, 1);
        wr("R4 addr hi ack", hi, 1);
        wr("R4 addr lo ack", lo, 1);
    endtask

    task automatic set_reg_ptr(input logic [7:0] p);
        wr("R1 exp addr ack", 8'h40, 1);
        wr("R2 pointer ack", p, 1);
    endtask

    initial begin
        tick(200000);
        check(1'b0, "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        tick(3);
        @(negedge clk);
        check(sda_oe == 1'b0, "R10 sda released in reset", int'(sda_oe), 0);
        rst_n = 1'b1;
        tick(4);
        @(negedge clk);
        check(exp_out == 8'h00, "R10 reg1 reset", int'(exp_out), 0);

        // R10: reset contents via reads
        i2c_start(); set_reg_ptr(8'h00);
        i2c_start(); wr("R6 exp read addr ack", 8'h41, 1);
        rd("R10 reg0 reset 01", 8'h01, 0);
        rd("R10 reg1 reset 00", 8'h00, 1);
        i2c_stop();

        // R2: pointer then data
        i2c_start(); set_reg_ptr(8'h01);
        wr("R2 data ack", 8'hA5, 1);
        wr("R2 data ack", 8'h3C, 1);
        i2c_stop();
        @(negedge clk);
        check(exp_out == 8'hA5, "R2 exp_out from reg1", int'(exp_out), 8'hA5);

        // R6 / R3: repeated start reads from pointer and increments
        i2c_start(); set_reg_ptr(8'h01);
        i2c_start(); wr("R6 exp read addr ack", 8'h41, 1);
        rd("R6 reg1 readback", 8'hA5, 0);
        rd("R3 reg2 after increment", 8'h3C, 0);
        rd("R3 reg3", 8'h00, 1);
        i2c_stop();

        // R3: wrap from 7 to 0
        i2c_start(); set_reg_ptr(8'h07);
        wr("R3 write reg7 ack", 8'h77, 1);
        wr("R3 write reg0 after wrap ack", 8'h11, 1);
        i2c_start(); set_reg_ptr(8'h07);
        i2c_start(); wr("R6 exp read addr ack", 8'h41, 1);
        rd("R3 reg7", 8'h77, 0);
        rd("R3 reg0 after wrap", 8'h11, 1);
        i2c_stop();

        // R1: foreign addresses are NACKed
        i2c_start(); wr("R1 foreign addr nack", 8'h66, 0); i2c_stop();
        i2c_start(); wr("R1 wrong strap nack", 8'h42, 0); i2c_stop();
        i2c_start(); wr("R1 wrong strap store nack", 8'hA2, 0); i2c_stop();

        // R4: store write and readback
        i2c_start(); set_mem_ptr(8'h01, 8'h20);
        wr("R4 data ack", 8'hDE, 1);
        wr("R4 data ack", 8'hAD, 1);
        i2c_start(); set_mem_ptr(8'h01, 8'h20);
        i2c_start(); wr("R6 store read addr ack", 8'hA1, 1);
        rd("R4 byte at 0x120", 8'hDE, 0);
        rd("R5 byte at 0x121", 8'hAD, 1);
        i2c_stop();

        // R5: wrap at top of store, high address bits beyond width ignored
        i2c_start(); set_mem_ptr(8'hFF, 8'hFF);
        wr("R5 data ack", 8'h5A, 1);
        wr("R5 data after wrap ack", 8'h6B, 1);
        i2c_start(); set_mem_ptr(8'h01, 8'hFF);
        i2c_start(); wr("R6 store read addr ack", 8'hA1, 1);
        rd("R5 byte at 0x1FF", 8'h5A, 0);
        rd("R5 byte at 0x000 after wrap", 8'h6B, 1);
        i2c_stop();

        // R7: blocked writes acked but not stored
        wr_block = 1'b1;
        i2c_start(); set_mem_ptr(8'h01, 8'h20);
        wr("R7 blocked data ack", 8'h00, 1);
        wr("R7 blocked data ack", 8'h99, 1);
        wr("R7 blocked data ack", 8'h12, 1);
        i2c_stop();
        wr_block = 1'b0;
        i2c_start(); set_mem_ptr(8'h01, 8'h20);
        i2c_start(); wr("R6 store read addr ack", 8'hA1, 1);
        rd("R7 0x120 unchanged", 8'hDE, 0);
        rd("R7 0x121 unchanged", 8'hAD, 1);
        i2c_stop();
        // pointer advanced past blocked bytes: write one byte after them
        i2c_start(); set_mem_ptr(8'h01, 8'h20);
        wr_block = 1'b1;
        wr("R7 blocked data ack", 8'h01, 1);
        wr_block = 1'b0;
        wr("R7 store after blocked byte ack", 8'hC3, 1);
        i2c_start(); set_mem_ptr(8'h01, 8'h20);
        i2c_start(); wr("R6 store read addr ack", 8'hA1, 1);
        rd("R7 blocked byte kept", 8'hDE, 0);
        rd("R7 pointer advanced past blocked byte", 8'hC3, 1);
        i2c_stop();

        // R8: store disabled by register 0 bit 0
        i2c_start(); set_reg_ptr(8'h00);
        wr("R8 clear enable ack", 8'h00, 1);
        i2c_stop();
        i2c_start(); wr("R8 store addr nack when disabled", 8'hA0, 0); i2c_stop();
        i2c_start(); set_reg_ptr(8'h00);
        wr("R8 set enable ack", 8'h01, 1);
        i2c_stop();
        i2c_start(); wr("R8 store addr ack when enabled", 8'hA0, 1); i2c_stop();

        // R9: after master NACK the slave stays off the bus
        i2c_start(); set_reg_ptr(8'h01);
        i2c_start(); wr("R6 exp read addr ack", 8'h41, 1);
        rd("R9 reg1 before nack", 8'hA5, 1);
        m_sda = 1'b1;
        for (int i = 0; i < 9; i++) begin
            tick(Q); m_scl = 1'b1; tick(Q/2);
            @(negedge clk);
            check(sda_line == 1'b1, "R9 SDA released after nack", int'(sda_line), 1);
            tick(Q/2); m_scl = 1'b0; tick(2);
        end
        i2c_stop();

        // R11: stop inside the address byte abandons it
        i2c_start();
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b0); put_bit(1'b0);
        i2c_stop();
        @(negedge clk);
        check(sda_oe == 1'b0, "R11 released after early stop", int'(sda_oe), 0);
        i2c_start(); wr("R11 fresh address after stop ack", 8'h40, 1);
        wr("R11 pointer ack", 8'h02, 1);
        i2c_start(); wr("R11 restart read addr ack", 8'h41, 1);
        rd("R11 reg2 readback", 8'h3C, 1);
        i2c_stop();

        tick(4);
        check(exp_q.size() == 0, "scoreboard leftover", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule